// File: doc/BRIEF.md
# Snapshot 3x3 Box Averager

This block replaces every element of a 16x16 array of signed 32-bit integers with the truncated mean of its 3x3 neighbourhood. The array lives in an external synchronous memory with a one-cycle read latency that serves one access per cycle. The block is both the only reader and the only writer of that memory while it runs.

A start pulse from idle launches a run with two phases that never overlap. In the first phase the block reads all 256 elements, in ascending address order, into a private tile buffer. In the second phase it computes one result per cycle from that buffer and writes it back over the source element. The write phase opens only after the last element has been captured, so every window sees the original data and never a value that was already written back. A single-cycle done pulse closes the run.

Top module: `tile_box_average`

## Requirements
- R1: After reset the block is idle: `mem_rd_en`, `mem_wr_en` and `done` are low.
- R2: A start sampled high while idle produces 256 consecutive read cycles beginning on the next cycle, at addresses 0 to 255 in ascending order. Address = row*16 + column.
- R3: A write never occurs in the same cycle as a read. The first write occurs two cycles after the read of address 255, once all 256 elements sit in the tile buffer.
- R4: Each result is the sum of the 3x3 neighbourhood centred on the element, divided by 9 with signed division truncated toward zero. Neighbours outside the 16x16 range add zero, and the divisor stays 9.
- R5: Results are written in place, one per cycle, on 256 consecutive cycles at addresses 0 to 255 ascending. Each result goes to the address of its own element.
- R6: Every window is taken from the copy loaded in the first phase, so values written back earlier in a run never affect later results.
- R7: `done` is high for exactly one cycle, the cycle after the write of address 255.
- R8: A start that arrives while a run is in progress, including the done cycle, has no effect.
- R9: Read data is taken from `mem_rdata` one cycle after the matching read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a run when the block is idle |
| mem_rd_en | output | 1 | Read request to the external array |
| mem_wr_en | output | 1 | Write request to the external array |
| mem_addr | output | 8 | Element address, row*16 + column |
| mem_wdata | output | 32 | Averaged result to write |
| mem_rdata | input | 32 | Read data, valid one cycle after the request |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
A phase counter or pipeline index that is off by one shows up at the ports on the first cycle it matters. Examples are a shifted read address, a write that opens during the load phase, or a done pulse that comes early or late. The per-cycle comparison catches each of these on that same clock. A buffer entry captured into the wrong slot, or a window that reads write-back data, stays silent until the first result that uses the entry. It then appears as a wrong `mem_wdata` value on that write cycle. Patterns of all -1 and of extreme values expose truncation and overflow mistakes in the corner, edge and interior results.

// File: rtl/tile_box_average.sv
module tile_box_average #(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  parameter int DW   = 32,
  localparam int N   = ROWS * COLS,
  localparam int AW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done
);
  localparam int SW = DW + 4;
  localparam logic signed [SW-1:0] NINE = SW'(9);

  typedef enum logic [1:0] {IDLE, LOAD, CALC, FIN} phase_t;

  phase_t             phase;
  logic [AW:0]        cnt;
  logic signed [DW-1:0] tile [N];
  logic signed [SW-1:0] acc, quot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        IDLE: if (start) begin
          phase <= LOAD;
          cnt   <= '0;
        end
        LOAD: if (cnt == (AW+1)'(N)) begin
          phase <= CALC;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        CALC: if (cnt == (AW+1)'(N-1)) phase <= FIN;
              else cnt <= cnt + 1'b1;
        default: phase <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (phase == LOAD && cnt != '0)
      tile[cnt[AW-1:0] - 1'b1] <= mem_rdata;

  always_comb begin
    int row, col, rr, cc, idx;
    row = int'(cnt[AW-1:0]) / COLS;
    col = int'(cnt[AW-1:0]) % COLS;
    acc = '0;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++) begin
        rr  = row + dr;
        cc  = col + dc;
        idx = rr * COLS + cc;
        if (rr >= 0 && rr < ROWS && cc >= 0 && cc < COLS)
          acc = acc + tile[idx[AW-1:0]];
      end
    quot = acc / NINE;
  end

  assign mem_rd_en = (phase == LOAD) && (cnt != (AW+1)'(N));
  assign mem_wr_en = (phase == CALC);
  assign mem_addr  = cnt[AW-1:0];
  assign mem_wdata = quot[DW-1:0];
  assign done      = (phase == FIN);

  a_r3_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  a_r3_write_after_barrier: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_en) |-> ($past(mem_rd_en, 2) && $past(mem_addr, 2) == AW'(N-1)));

  a_r2_read_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> mem_addr == $past(mem_addr) + 1'b1);

  a_r5_write_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && $past(mem_wr_en)) |-> mem_addr == $past(mem_addr) + 1'b1);

  a_r7_done_after_last_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_wr_en) && $past(mem_addr) == AW'(N-1)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !mem_rd_en);
endmodule

// File: tb/tile_box_average_tb.sv
module tile_box_average_tb;
  logic clk = 0, rst_n = 0, start = 0;
  logic mem_rd_en, mem_wr_en, done;
  logic [7:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic signed [31:0] mem  [256];
  logic signed [31:0] snap [256];
  int k = -1;
  int checks = 0, fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  tile_box_average u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
  end

  function automatic logic signed [31:0] ref_avg(int idx);
    longint s = 0;
    int r = idx / 16, c = idx % 16;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++)
        if (r+dr >= 0 && r+dr < 16 && c+dc >= 0 && c+dc < 16)
          s += longint'(snap[(r+dr)*16 + c+dc]);
    return 32'(s / 9);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, k);
    end
  endtask

  // cycle-level reference model: R8 -- start only counts while idle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) k <= -1;
    else if (k < 0) begin
      if (start) begin
        k <= 0;
        for (int i = 0; i < 256; i++) snap[i] = mem[i];
      end
    end else if (k >= 513) k <= -1;
    else k <= k + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk("R2/R8 rd_en", longint'(mem_rd_en), longint'(k >= 0 && k < 256));
      chk("R3/R5 wr_en", longint'(mem_wr_en), longint'(k >= 257 && k <= 512));
      chk("R7 done", longint'(done), longint'(k == 513));
      if (mem_rd_en && k >= 0 && k < 256) chk("R2 rd addr", longint'(mem_addr), longint'(k));
      if (mem_wr_en && k >= 257 && k <= 512) begin
        chk("R5 wr addr", longint'(mem_addr), longint'(k - 257));
        chk("R4/R6/R9 wdata", longint'($signed(mem_wdata)), longint'(ref_avg(k - 257)));
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run(bit poke_start);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (k >= 0) begin
      @(negedge clk);
      if (poke_start && (k == 100 || k == 256 || k == 400 || k == 513)) start = 1;
      else start = 0;
    end
    start = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 256; i++) chk("R6 final mem", longint'(mem[i]), longint'(ref_avg(i)));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = $signed($urandom);
    repeat (3) @(negedge clk);
    chk("R1 rd_en reset", longint'(mem_rd_en), 0);
    chk("R1 wr_en reset", longint'(mem_wr_en), 0);
    chk("R1 done reset", longint'(done), 0);
    rst_n = 1;
    @(negedge clk);

    run(0);

    for (int i = 0; i < 256; i++) mem[i] = -1;
    run(0);
    chk("R4 corner trunc", longint'(mem[0]), 0);
    chk("R4 edge trunc", longint'(mem[5]), 0);
    chk("R4 interior", longint'(mem[17]), -1);

    for (int i = 0; i < 256; i++) mem[i] = 32'sh7fffffff;
    run(1);
    chk("R4 max interior", longint'(mem[100]), 64'sd2147483647);
    chk("R8 idle after ignored start", longint'(mem_rd_en), 0);

    for (int i = 0; i < 256; i++) mem[i] = (i % 2) ? 32'sh80000000 : i * 1000 - 70000;
    run(1);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule